// File: doc/BRIEF.md
# Audio Serial Port Register Front-End

This block is the host side of a stereo audio serial port. A processor reaches it over a simple memory-mapped bus with separate read and write strobes and byte offsets. Through this bus it sets up the link, reads a status word, enables interrupts, clears error flags and moves audio words through one shared data port. Writes to that port fill a 16-word transmit FIFO. Reads from the same port drain a 16-word receive FIFO.

The serial bit engine outside this block takes words from the transmit FIFO with a pop strobe. It delivers received words with a push strobe. It reports underruns, overruns and frame activity as single-cycle pulses or levels. The block raises per-direction service requests against programmable watermarks. These requests drive two DMA request lines, and together with the sticky error flags they feed one maskable interrupt line. A self-clearing soft-reset bit in the global control word empties both FIFOs and returns every register to its reset value.

Top module: `aud_port_regs`

## Requirements
- R1: Registers sit at byte offsets 0x00 (global control), 0x04 (format control), 0x0C (status), 0x14 (interrupt enable), 0x18 (flag clear), 0x60 (clock divider) and 0x80 (data port). Read data appears on `host_rdata` in the cycle after the read strobe. Only implemented bits read back: global control mask 0xFF05, format 0x39, interrupt enable 0x78, divider 0x7F. The clear register and unmapped offsets read 0.
- R2: After reset, global control reads 0xE100 (receive watermark 14 in bits 15:12, transmit watermark 1 in bits 11:8). Format, enable and divider read 0. Status reads 0x89. `irq` is 0.
- R3: A data-port write pushes the word into the transmit FIFO. The engine sees words in write order on `eng_tx_data` while `eng_tx_avail` is 1. A write to a full FIFO (16 words) is dropped. A pop of an empty FIFO changes nothing.
- R4: A data-port read returns the oldest receive word and removes it. A read of an empty receive FIFO returns 0 and leaves the pointers unchanged. An engine push into a full receive FIFO is dropped.
- R5: The receive service request (status bit 4, `rx_dma_req`) is 1 exactly while the receive level is at least the receive watermark.
- R6: The transmit service request (status bit 3, `tx_dma_req`) is 1 exactly while the transmit level is at most the transmit watermark. Status bit 0 is 1 while the transmit FIFO is not full.
- R7: An `eng_tx_underrun` pulse sets sticky status bit 5. An `eng_rx_overrun` pulse sets sticky bit 6. Writing 1 to bit 5 or bit 6 of the clear register clears the matching flag, and writing 0 has no effect. A set pulse in the same cycle as a clear wins.
- R8: `irq` is the OR of status bits 3 to 6, each ANDed with the interrupt enable bit at the same position.
- R9: Writing global control with bit 3 set empties both FIFOs and restores every register to its reset value. Bit 3 always reads 0.
- R10: Status bit 2 follows `eng_busy`. Status bit 7 is 1 when the link enable (global bit 0) is 0 and `eng_busy` is 0.
- R11: The configuration outputs drive the engine: `cfg_link_en` (global bit 0), `cfg_clk_drive` (global bit 2, 1 = this port drives the bit clock), `cfg_alt_fmt` (format bit 0), `cfg_rec_off` (bit 3), `cfg_play_off` (bit 4), `cfg_loopback` (bit 5) and `cfg_div` (divider bits 6:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Bus write strobe |
| host_rd | input | 1 | Bus read strobe |
| host_addr | input | 8 | Byte offset |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Registered read data |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head of the transmit FIFO |
| eng_tx_avail | output | 1 | Transmit FIFO holds a word |
| eng_tx_underrun | input | 1 | Underrun pulse from the engine |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | 32 | Received word |
| eng_rx_overrun | input | 1 | Overrun pulse from the engine |
| eng_busy | input | 1 | Engine is inside a frame |
| cfg_link_en | output | 1 | Link enable |
| cfg_clk_drive | output | 1 | Port drives the bit clock |
| cfg_alt_fmt | output | 1 | Left-justified framing select |
| cfg_rec_off | output | 1 | Recording disabled |
| cfg_play_off | output | 1 | Playback disabled |
| cfg_loopback | output | 1 | Internal loopback |
| cfg_div | output | 7 | Clock divider value |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit service request |
| rx_dma_req | output | 1 | Receive service request |

## Verification
A wrong FIFO pointer or count shows within one access. It appears as a misordered or repeated word on the data port or `eng_tx_data`, or as a status or DMA line that flips at the wrong fill level. The bench steps through every level around both watermarks and the full and empty edges. A lost or stuck sticky flag shows on `irq` and status bit 5 or 6 in the cycle after the pulse or the clear write. A soft reset that misses one register shows in the read-back right after it.

// File: rtl/aud_port_pkg.sv
package aud_port_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int FIFO_DEPTH = 16;
    localparam int THR_W      = 4;
    localparam int DIV_W      = 7;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FMT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h80;

    // global control bit positions
    localparam int GC_LINK   = 0;
    localparam int GC_CLKDRV = 2;
    localparam int GC_SRST   = 3;
    localparam int GC_TXTHR  = 8;
    localparam int GC_RXTHR  = 12;

    // format control bit positions
    localparam int FC_ALT     = 0;
    localparam int FC_RECOFF  = 3;
    localparam int FC_PLAYOFF = 4;
    localparam int FC_LOOP    = 5;

    // status / enable / clear bit positions
    localparam int ST_TXNF  = 0;
    localparam int ST_RXNE  = 1;
    localparam int ST_BUSY  = 2;
    localparam int ST_TXSVC = 3;
    localparam int ST_RXSVC = 4;
    localparam int ST_TUR   = 5;
    localparam int ST_ROR   = 6;
    localparam int ST_OFF   = 7;

    localparam logic [THR_W-1:0] RX_THR_RST = 4'd14;
    localparam logic [THR_W-1:0] TX_THR_RST = 4'd1;

    typedef struct packed {
        logic              link_en;
        logic              clk_drv;
        logic [THR_W-1:0]  tx_thr;
        logic [THR_W-1:0]  rx_thr;
        logic              alt_fmt;
        logic              rec_off;
        logic              play_off;
        logic              loop_en;
        logic [3:0]        ien;      // {ror, tur, rxsvc, txsvc}
        logic [DIV_W-1:0]  div;
        logic              tur;
        logic              ror;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r        = '0;
        r.tx_thr = TX_THR_RST;
        r.rx_thr = RX_THR_RST;
        return r;
    endfunction

    typedef struct packed {
        logic txsvc;
        logic rxsvc;
    } svc_t;

endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        full    = (st_q.cnt == FULL_CNT);
        empty   = (st_q.cnt == '0);
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push)
                st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
            if (do_pop)
                st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr] <= push_data;
    end

    assign head  = mem_q[st_q.rptr];
    assign level = st_q.cnt;

    // R3
    fifo_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);

    // R4
    pop_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !flush) |=> $stable(st_q.rptr) && (st_q.cnt == '0));

    // R3
    push_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(st_q.wptr) && full);

endmodule

// File: rtl/aud_svc.sv
module aud_svc
    import aud_port_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             tur,
    input  logic             ror,
    input  logic [3:0]       ien,
    output svc_t             svc,
    output logic             irq
);
    logic [3:0] cause;

    always_comb begin
        svc.txsvc = (32'(tx_lvl) <= 32'(tx_thr));
        svc.rxsvc = (32'(rx_lvl) >= 32'(rx_thr));
        cause     = {ror, tur, svc.rxsvc, svc.txsvc};
        irq       = |(cause & ien);
    end

endmodule

// File: rtl/aud_port_regs.sv
module aud_port_regs
    import aud_port_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_tx_underrun,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_rx_overrun,
    input  logic              eng_busy,
    output logic              cfg_link_en,
    output logic              cfg_clk_drive,
    output logic              cfg_alt_fmt,
    output logic              cfg_rec_off,
    output logic              cfg_play_off,
    output logic              cfg_loopback,
    output logic [DIV_W-1:0]  cfg_div,
    output logic              irq,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    regs_t st_d, st_q;

    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic              tx_push, rx_pop, soft_rst;
    logic              wr_ctrl, wr_fmt, wr_ien, wr_clr, wr_div;
    logic [7:0]        status;
    logic [DATA_W-1:0] rd_mux;
    svc_t              svc;

    // ---------------- FIFO pair ----------------
    aud_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (tx_push),
        .push_data (host_wdata),
        .pop       (eng_tx_pop),
        .head      (eng_tx_data),
        .level     (tx_lvl),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    aud_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // ---------------- watermarks and interrupt ----------------
    aud_svc #(.LVL_W(LVL_W)) u_svc (
        .tx_lvl (tx_lvl),
        .rx_lvl (rx_lvl),
        .tx_thr (st_q.tx_thr),
        .rx_thr (st_q.rx_thr),
        .tur    (st_q.tur),
        .ror    (st_q.ror),
        .ien    (st_q.ien),
        .svc    (svc),
        .irq    (irq)
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        wr_ctrl  = host_wr && (host_addr == OFS_CTRL);
        wr_fmt   = host_wr && (host_addr == OFS_FMT);
        wr_ien   = host_wr && (host_addr == OFS_IEN);
        wr_clr   = host_wr && (host_addr == OFS_CLR);
        wr_div   = host_wr && (host_addr == OFS_DIV);
        tx_push  = host_wr && (host_addr == OFS_DATA);
        rx_pop   = host_rd && (host_addr == OFS_DATA);
        soft_rst = wr_ctrl && host_wdata[GC_SRST];

        status           = '0;
        status[ST_TXNF]  = !tx_full;
        status[ST_RXNE]  = !rx_empty;
        status[ST_BUSY]  = eng_busy;
        status[ST_TXSVC] = svc.txsvc;
        status[ST_RXSVC] = svc.rxsvc;
        status[ST_TUR]   = st_q.tur;
        status[ST_ROR]   = st_q.ror;
        status[ST_OFF]   = !st_q.link_en && !eng_busy;

        rd_mux = '0;
        case (host_addr)
            OFS_CTRL: begin
                rd_mux[GC_LINK]                 = st_q.link_en;
                rd_mux[GC_CLKDRV]               = st_q.clk_drv;
                rd_mux[GC_TXTHR +: THR_W]       = st_q.tx_thr;
                rd_mux[GC_RXTHR +: THR_W]       = st_q.rx_thr;
            end
            OFS_FMT: begin
                rd_mux[FC_ALT]     = st_q.alt_fmt;
                rd_mux[FC_RECOFF]  = st_q.rec_off;
                rd_mux[FC_PLAYOFF] = st_q.play_off;
                rd_mux[FC_LOOP]    = st_q.loop_en;
            end
            OFS_STAT: rd_mux[7:0]             = status;
            OFS_IEN:  rd_mux[ST_TXSVC +: 4]   = st_q.ien;
            OFS_DIV:  rd_mux[DIV_W-1:0]       = st_q.div;
            OFS_DATA: rd_mux                  = rx_empty ? '0 : rx_head;
            default:  rd_mux                  = '0;
        endcase

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.link_en = host_wdata[GC_LINK];
            st_d.clk_drv = host_wdata[GC_CLKDRV];
            st_d.tx_thr  = host_wdata[GC_TXTHR +: THR_W];
            st_d.rx_thr  = host_wdata[GC_RXTHR +: THR_W];
        end
        if (wr_fmt) begin
            st_d.alt_fmt  = host_wdata[FC_ALT];
            st_d.rec_off  = host_wdata[FC_RECOFF];
            st_d.play_off = host_wdata[FC_PLAYOFF];
            st_d.loop_en  = host_wdata[FC_LOOP];
        end
        if (wr_ien) st_d.ien = host_wdata[ST_TXSVC +: 4];
        if (wr_div) st_d.div = host_wdata[DIV_W-1:0];

        if (wr_clr && host_wdata[ST_TUR]) st_d.tur = 1'b0;
        if (wr_clr && host_wdata[ST_ROR]) st_d.ror = 1'b0;
        if (eng_tx_underrun) st_d.tur = 1'b1;
        if (eng_rx_overrun)  st_d.ror = 1'b1;

        if (host_rd) st_d.rdata = rd_mux;

        if (soft_rst) st_d = regs_reset();
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= regs_reset();
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    assign host_rdata    = st_q.rdata;
    assign eng_tx_avail  = !tx_empty;
    assign cfg_link_en   = st_q.link_en;
    assign cfg_clk_drive = st_q.clk_drv;
    assign cfg_alt_fmt   = st_q.alt_fmt;
    assign cfg_rec_off   = st_q.rec_off;
    assign cfg_play_off  = st_q.play_off;
    assign cfg_loopback  = st_q.loop_en;
    assign cfg_div       = st_q.div;
    assign tx_dma_req    = svc.txsvc;
    assign rx_dma_req    = svc.rxsvc;

    // ---------------- assertions ----------------
    // R7
    tur_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_tx_underrun && !soft_rst) |=> st_q.tur);

    // R7
    ror_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_overrun && !soft_rst) |=> st_q.ror);

    // R7
    tur_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && host_wdata[ST_TUR] && !eng_tx_underrun) |=> !st_q.tur);

    // R9
    srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (tx_lvl == '0) && (rx_lvl == '0) && !st_q.link_en);

    // R4
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_pop && !soft_rst) |=> rx_full);

endmodule

// File: tb/aud_port_regs_tb.sv
module aud_port_regs_tb;
    import aud_port_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              eng_tx_pop = 1'b0;
    logic [DATA_W-1:0] eng_tx_data;
    logic              eng_tx_avail;
    logic              eng_tx_underrun = 1'b0;
    logic              eng_rx_push = 1'b0;
    logic [DATA_W-1:0] eng_rx_data = '0;
    logic              eng_rx_overrun = 1'b0;
    logic              eng_busy = 1'b0;
    logic              cfg_link_en, cfg_clk_drive, cfg_alt_fmt;
    logic              cfg_rec_off, cfg_play_off, cfg_loopback;
    logic [DIV_W-1:0]  cfg_div;
    logic              irq, tx_dma_req, rx_dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    aud_port_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_tx_underrun(eng_tx_underrun),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_rx_overrun(eng_rx_overrun), .eng_busy(eng_busy),
        .cfg_link_en(cfg_link_en), .cfg_clk_drive(cfg_clk_drive),
        .cfg_alt_fmt(cfg_alt_fmt), .cfg_rec_off(cfg_rec_off),
        .cfg_play_off(cfg_play_off), .cfg_loopback(cfg_loopback),
        .cfg_div(cfg_div), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic tx_pop();
        @(negedge clk); eng_tx_pop = 1'b1;
        @(negedge clk); eng_tx_pop = 1'b0;
    endtask

    task automatic rx_push(input logic [31:0] d);
        @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk); eng_rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFS_CTRL, v); chk("R2 ctrl reset", v, 32'h0000_E100);
        rd(OFS_STAT, v); chk("R2 status reset", v, 32'h89);
        rd(OFS_FMT, v);  chk("R2 fmt reset", v, 0);
        rd(OFS_IEN, v);  chk("R2 ien reset", v, 0);
        rd(OFS_DIV, v);  chk("R2 div reset", v, 0);
        chk("R2 irq reset", irq, 0);
        chk("R6 tx req reset", tx_dma_req, 1);
        chk("R5 rx req reset", rx_dma_req, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(OFS_CTRL, 32'hFFFF_FFF7); rd(OFS_CTRL, v); chk("R1 ctrl mask", v, 32'hFF05);
        wr(OFS_FMT, 32'hFFFF_FFFF);  rd(OFS_FMT, v);  chk("R1 fmt mask", v, 32'h39);
        wr(OFS_IEN, 32'hFFFF_FFFF);  rd(OFS_IEN, v);  chk("R1 ien mask", v, 32'h78);
        wr(OFS_DIV, 32'hFFFF_FFFF);  rd(OFS_DIV, v);  chk("R1 div mask", v, 32'h7F);
        rd(OFS_CLR, v); chk("R1 clear reads zero", v, 0);
        rd(8'h40, v);   chk("R1 unmapped reads zero", v, 0);
        chk("R11 link out", cfg_link_en, 1);
        chk("R11 clk drive out", cfg_clk_drive, 1);
        chk("R11 fmt outs", {cfg_loopback, cfg_play_off, cfg_rec_off, cfg_alt_fmt}, 4'hF);
        chk("R11 div out", cfg_div, 7'h7F);
        chk("R8 irq txsvc enabled", irq, 1);
        wr(OFS_CTRL, 32'h0000_E100);
        wr(OFS_FMT, 0); wr(OFS_IEN, 0); wr(OFS_DIV, 32'h0C);
        chk("R11 div value", cfg_div, 7'h0C);
        chk("R11 fmt off", {cfg_loopback, cfg_play_off, cfg_rec_off, cfg_alt_fmt}, 4'h0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) wr(OFS_DATA, 32'h100 + i);
        rd(OFS_STAT, v);
        chk("R6 tx full status", v[ST_TXNF], 0);
        chk("R6 tx req at 16", tx_dma_req, 0);
        wr(OFS_DATA, 32'h999);
        for (int i = 0; i < 16; i++) begin
            chk("R3 tx order", eng_tx_data, 32'h100 + i);
            tx_pop();
            if (i == 13) chk("R6 tx req at level 2", tx_dma_req, 0);
            if (i == 14) chk("R6 tx req at level 1", tx_dma_req, 1);
        end
        chk("R3 full write dropped", eng_tx_avail, 0);
        tx_pop();
        wr(OFS_DATA, 32'h77);
        chk("R3 pop on empty ignored", eng_tx_data, 32'h77);
        tx_pop();
        chk("R3 tx drained", eng_tx_avail, 0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            rx_push(32'h200 + i);
            if (i == 12) chk("R5 rx req at 13", rx_dma_req, 0);
            if (i == 13) chk("R5 rx req at 14", rx_dma_req, 1);
        end
        rx_push(32'hDEAD);
        rd(OFS_STAT, v);
        chk("R4 rx not empty", v[ST_RXNE], 1);
        chk("R5 rx svc status", v[ST_RXSVC], 1);
        for (int i = 0; i < 16; i++) begin
            rd(OFS_DATA, v);
            chk("R4 rx order", v, 32'h200 + i);
        end
        rd(OFS_DATA, v); chk("R4 empty read zero", v, 0);
        rx_push(32'h55);
        rd(OFS_DATA, v); chk("R4 pointers kept", v, 32'h55);
        chk("R5 rx req empty", rx_dma_req, 0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        @(negedge clk); eng_tx_underrun = 1'b1;
        @(negedge clk); eng_tx_underrun = 1'b0;
        rd(OFS_STAT, v); chk("R7 underrun set", v[ST_TUR], 1);
        wr(OFS_IEN, 32'h20); chk("R8 irq on underrun", irq, 1);
        wr(OFS_CLR, 32'h0);  rd(OFS_STAT, v); chk("R7 zero write no effect", v[ST_TUR], 1);
        wr(OFS_CLR, 32'h40); rd(OFS_STAT, v); chk("R7 other bit no effect", v[ST_TUR], 1);
        wr(OFS_CLR, 32'h20); rd(OFS_STAT, v); chk("R7 underrun cleared", v[ST_TUR], 0);
        chk("R8 irq drops", irq, 0);
        @(negedge clk); eng_rx_overrun = 1'b1;
        @(negedge clk); eng_rx_overrun = 1'b0;
        rd(OFS_STAT, v); chk("R7 overrun set", v[ST_ROR], 1);
        wr(OFS_CLR, 32'h40); rd(OFS_STAT, v); chk("R7 overrun cleared", v[ST_ROR], 0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = OFS_CLR; host_wdata = 32'h40; eng_rx_overrun = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_rx_overrun = 1'b0;
        rd(OFS_STAT, v); chk("R7 set beats clear", v[ST_ROR], 1);
        wr(OFS_CLR, 32'h60);
        wr(OFS_IEN, 32'h08); chk("R8 irq on txsvc", irq, 1);
        wr(OFS_IEN, 32'h10); chk("R8 rxsvc below mark", irq, 0);
        wr(OFS_IEN, 0);
    endtask

    task automatic t_off();
        logic [31:0] v;
        rd(OFS_STAT, v); chk("R10 off when idle", v[ST_OFF], 1);
        eng_busy = 1'b1;
        rd(OFS_STAT, v);
        chk("R10 busy mirrors", v[ST_BUSY], 1);
        chk("R10 not off while busy", v[ST_OFF], 0);
        eng_busy = 1'b0;
        wr(OFS_CTRL, 32'h0000_E101);
        rd(OFS_STAT, v); chk("R10 not off when enabled", v[ST_OFF], 0);
    endtask

    task automatic t_softrst();
        logic [31:0] v;
        wr(OFS_CTRL, 32'h0000_5505);
        wr(OFS_FMT, 32'h39); wr(OFS_IEN, 32'h78); wr(OFS_DIV, 32'h11);
        for (int i = 0; i < 3; i++) wr(OFS_DATA, i);
        rx_push(32'hA); rx_push(32'hB);
        @(negedge clk); eng_tx_underrun = 1'b1;
        @(negedge clk); eng_tx_underrun = 1'b0;
        wr(OFS_CTRL, 32'h0000_0008);
        rd(OFS_CTRL, v); chk("R9 ctrl restored", v, 32'h0000_E100);
        rd(OFS_FMT, v);  chk("R9 fmt cleared", v, 0);
        rd(OFS_IEN, v);  chk("R9 ien cleared", v, 0);
        rd(OFS_DIV, v);  chk("R9 div cleared", v, 0);
        rd(OFS_STAT, v); chk("R9 status restored", v, 32'h89);
        chk("R9 tx fifo empty", eng_tx_avail, 0);
        rd(OFS_DATA, v); chk("R9 rx fifo empty", v, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_tx();
        t_rx();
        t_sticky();
        t_off();
        t_softrst();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule